// File: doc/BRIEF.md
# Configuration ROM Entry Walker

The walker parses a configuration image stored byte by byte in a local buffer that the block reads through a synchronous port with one cycle of latency. A pulse on `start` makes it fetch the header fields it needs: the revision byte and the two-byte data-length word. From these it works out the total image size. It then follows the chain of length-prefixed entries that begins right after the fixed header. Each entry produces one decoded record on a valid/ready stream. A record carries the entry kind, its index, the disabled flag, the link number and partner fields for port entries, and the name kind and string length for generic entries.

The record stream follows the usual back-pressure rules. While `rec_valid` is high and `rec_ready` is low, the record holds steady and the walker neither reads ahead nor advances. A record is transferred in any cycle where both signals are high. When the chain ends exactly at the image size, the walk ends with a one-cycle `done` pulse. A malformed image stops the walk, and a nonzero `err_code` is held until the next `start`. A revision above the supported maximum raises `rev_warn`, which is only a warning and does not stop the walk.

Top module: `cfgrom_walker`

## Requirements
- R1: After reset, `busy`, `done`, `rec_valid` and `rev_warn` are 0 and `err_code` is 0.
- R2: Total size is taken from the little-endian word at bytes 14 (low) and 15 (high). The walker keeps its low 10 bits and adds 13; the upper six bits are ignored. A size below 22 ends the walk with `err_code`=1 and emits no record. A size of exactly 22 ends with `done` and no record.
- R3: Entries start at byte 22 and are reported in chain order, with the position advancing by each entry's length. `done` pulses for one cycle once the position equals the size exactly.
- R4: Entry byte 0 is the entry length, counting the 2-byte entry header. In entry byte 1, bits 5:0 give `rec_index`, bit 6 gives `rec_disabled`, and bit 7 gives `rec_is_port` (1 = port, 0 = generic).
- R5: The walk stops with `err_code`=2 in any of three cases: the entry length is 0, the position is exactly one byte short of the size, or position plus length exceeds the size. The offending entry produces no record. Records before it are still delivered.
- R6: A port entry whose disabled flag is clear must be exactly 8 bytes long; any other length stops the walk with `err_code`=3.
- R7: For an enabled port entry, `rec_link` is byte 2 bit 4 and `rec_has_partner` is byte 2 bit 7. `rec_partner` is byte 3 bits 5:0 when a partner exists and 0 otherwise. A disabled port entry reports link, partner flag and partner as 0, and its length is not checked.
- R8: For generic entries, index 1 gives `rec_name`=1 (vendor) and index 2 gives `rec_name`=2 (device), each with `rec_str_len` equal to the entry length minus 2. Any other index gives `rec_name`=0 and `rec_str_len`=0. Port entries report `rec_name`=0.
- R9: A revision byte (byte 13) greater than 2 sets `rev_warn` until the next `start`. It does not change the walk's outcome.
- R10: While `rec_valid` is high and `rec_ready` is low, every record field stays stable and the walker does not advance.
- R11: `rd_en` is never high on two consecutive cycles. Every address issued while reading an entry is below the total size.
- R12: `err_code` is held until the next `start`. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse on clean completion |
| err_code | output | 2 | 0 none, 1 image too small, 2 chain overrun, 3 bad port length |
| rev_warn | output | 1 | Revision byte above 2 |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | AW | Buffer byte address |
| rd_data | input | 8 | Buffer data, valid the cycle after `rd_en` |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts record |
| rec_is_port | output | 1 | 1 = port entry, 0 = generic |
| rec_index | output | 6 | Entry index |
| rec_disabled | output | 1 | Disabled flag |
| rec_link | output | 1 | Link number (port entries) |
| rec_has_partner | output | 1 | Dual-link partner exists |
| rec_partner | output | 6 | Partner port number |
| rec_name | output | 2 | 0 none, 1 vendor, 2 device |
| rec_str_len | output | 8 | Name string length |

## Verification
Two events can fall in the same cycle: the revision warning being raised, and the walk ending, either through `done` or through an error. Two tests provoke this. One image carries revision 3 together with a too-small length field. The other carries revision 0xFF together with a header-only length. In both, the bench checks that the warning is visible in the same sample as the outcome, and that the outcome is the one an image with a valid revision would give. Stalls on `rec_ready` are applied during a multi-entry walk, and a `start` pulse is injected mid-walk, to show that record delivery and ordering are unaffected.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  localparam int unsigned REV_OFS     = 13;
  localparam int unsigned LEN_OFS     = 14;
  localparam int unsigned HDR_BYTES   = 22;
  localparam int unsigned DATA_OFS    = 13;
  localparam int unsigned ENT_HDR     = 2;
  localparam int unsigned PORT_LEN    = 8;
  localparam int unsigned MAX_REV     = 2;
  localparam int unsigned TYPE_BIT    = 7;
  localparam int unsigned DIS_BIT     = 6;
  localparam int unsigned LINK_BIT    = 4;
  localparam int unsigned PARTNER_BIT = 7;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_SMALL    = 2'd1,
    ERR_OVERRUN  = 2'd2,
    ERR_PORT_LEN = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    NAME_NONE   = 2'd0,
    NAME_VENDOR = 2'd1,
    NAME_DEVICE = 2'd2
  } name_e;

  typedef struct packed {
    logic       is_port;
    logic [5:0] index;
    logic       disabled;
    logic       link;
    logic       has_partner;
    logic [5:0] partner;
    logic [1:0] name;
    logic [7:0] str_len;
  } rec_t;

endpackage

// File: rtl/cfgrom_fetch.sv
module cfgrom_fetch #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          ok_o,
  output logic [7:0]    data_o
);

  logic pend_q;

  assign rd_en_o   = req_i && !pend_q;
  assign rd_addr_o = addr_i;
  assign ok_o      = pend_q;
  assign data_o    = rd_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= rd_en_o;
  end

  AST_RD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o); // R11

endmodule

// File: rtl/cfgrom_entry_check.sv
module cfgrom_entry_check #(
  parameter int AW = 11
) (
  input  logic [AW-1:0] pos_i,
  input  logic [AW-1:0] size_i,
  input  logic [7:0]    len_i,
  input  logic [7:0]    hdr_i,
  output logic          overrun_o,
  output logic          is_port_o,
  output logic          disabled_o,
  output logic [5:0]    index_o,
  output logic          port_len_bad_o,
  output logic [AW-1:0] next_pos_o,
  output logic          at_end_o
);
  import cfgrom_pkg::*;

  localparam int CW = AW + 1;

  logic [CW-1:0] end_w, size_w, pos_w;

  assign pos_w  = {1'b0, pos_i};
  assign size_w = {1'b0, size_i};
  assign end_w  = pos_w + CW'(len_i);

  assign overrun_o = (len_i == 8'd0)
                  || (pos_w + CW'(1) == size_w)
                  || (end_w > size_w);

  assign is_port_o      = hdr_i[TYPE_BIT];
  assign disabled_o     = hdr_i[DIS_BIT];
  assign index_o        = hdr_i[5:0];
  assign port_len_bad_o = (len_i != 8'(PORT_LEN));
  assign next_pos_o     = end_w[AW-1:0];
  assign at_end_o       = (end_w == size_w);

endmodule

// File: rtl/cfgrom_rec_out.sv
module cfgrom_rec_out (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  cfgrom_pkg::rec_t     rec_i,
  output logic                 valid_o,
  input  logic                 ready_i,
  output cfgrom_pkg::rec_t     rec_o
);
  import cfgrom_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      rec_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      rec_o   <= rec_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_REC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(rec_o))); // R10
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o); // R10

endmodule

// File: rtl/cfgrom_walker.sv
module cfgrom_walker #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err_code,
  output logic          rev_warn,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic          rec_is_port,
  output logic [5:0]    rec_index,
  output logic          rec_disabled,
  output logic          rec_link,
  output logic          rec_has_partner,
  output logic [5:0]    rec_partner,
  output logic [1:0]    rec_name,
  output logic [7:0]    rec_str_len
);
  import cfgrom_pkg::*;

  localparam int CW = AW + 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REV, ST_LLO, ST_LHI, ST_SIZE, ST_ELEN, ST_ECHK,
    ST_EHDR, ST_DEC, ST_PB2, ST_PB3, ST_HOLD
  } st_e;

  st_e           st;
  logic [7:0]    lenlo_q, elen_q, ehdr_q, b2_q;
  logic [AW-1:0] size_q, pos_q;
  err_e          err_q;
  logic          warn_q, done_q;

  logic          f_req, f_ok;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_data;

  logic          ov, is_port, dis, plen_bad, at_end;
  logic [5:0]    idx;
  logic [AW-1:0] next_pos;
  logic [CW-1:0] size_calc;

  rec_t          pl, rec_q;
  logic          rec_load;

  // address selection per fetch state
  always_comb begin
    f_req  = 1'b1;
    f_addr = '0;
    unique case (st)
      ST_REV:  f_addr = AW'(REV_OFS);
      ST_LLO:  f_addr = AW'(LEN_OFS);
      ST_LHI:  f_addr = AW'(LEN_OFS + 1);
      ST_ELEN: f_addr = pos_q;
      ST_EHDR: f_addr = pos_q + AW'(1);
      ST_PB2:  f_addr = pos_q + AW'(2);
      ST_PB3:  f_addr = pos_q + AW'(3);
      default: f_req  = 1'b0;
    endcase
  end

  cfgrom_fetch #(.AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (f_req),
    .addr_i    (f_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .ok_o      (f_ok),
    .data_o    (f_data)
  );

  cfgrom_entry_check #(.AW(AW)) u_check (
    .pos_i          (pos_q),
    .size_i         (size_q),
    .len_i          (elen_q),
    .hdr_i          (ehdr_q),
    .overrun_o      (ov),
    .is_port_o      (is_port),
    .disabled_o     (dis),
    .index_o        (idx),
    .port_len_bad_o (plen_bad),
    .next_pos_o     (next_pos),
    .at_end_o       (at_end)
  );

  assign size_calc = CW'({f_data[1:0], lenlo_q}) + CW'(DATA_OFS);

  // record assembly
  always_comb begin
    pl          = '0;
    pl.is_port  = is_port;
    pl.index    = idx;
    pl.disabled = dis;
    if (st == ST_PB3) begin
      pl.link        = b2_q[LINK_BIT];
      pl.has_partner = b2_q[PARTNER_BIT];
      if (b2_q[PARTNER_BIT]) pl.partner = f_data[5:0];
    end
    if (!is_port) begin
      if (idx == 6'd1)      pl.name = NAME_VENDOR;
      else if (idx == 6'd2) pl.name = NAME_DEVICE;
      if (pl.name != NAME_NONE) pl.str_len = elen_q - 8'(ENT_HDR);
    end
  end

  assign rec_load = ((st == ST_DEC) && !(is_port && !dis))
                 || ((st == ST_PB3) && f_ok);

  cfgrom_rec_out u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rec_load),
    .rec_i   (pl),
    .valid_o (rec_valid),
    .ready_i (rec_ready),
    .rec_o   (rec_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lenlo_q <= '0;
      elen_q  <= '0;
      ehdr_q  <= '0;
      b2_q    <= '0;
      size_q  <= '0;
      pos_q   <= '0;
      err_q   <= ERR_NONE;
      warn_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          err_q  <= ERR_NONE;
          warn_q <= 1'b0;
          st     <= ST_REV;
        end
        ST_REV: if (f_ok) begin
          warn_q <= (f_data > 8'(MAX_REV));
          st     <= ST_LLO;
        end
        ST_LLO: if (f_ok) begin
          lenlo_q <= f_data;
          st      <= ST_LHI;
        end
        ST_LHI: if (f_ok) begin
          size_q <= size_calc[AW-1:0];
          st     <= ST_SIZE;
        end
        ST_SIZE: begin
          pos_q <= AW'(HDR_BYTES);
          if (size_q < AW'(HDR_BYTES)) begin
            err_q <= ERR_SMALL;
            st    <= ST_IDLE;
          end else if (size_q == AW'(HDR_BYTES)) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_ELEN;
          end
        end
        ST_ELEN: if (f_ok) begin
          elen_q <= f_data;
          st     <= ST_ECHK;
        end
        ST_ECHK: begin
          if (ov) begin
            err_q <= ERR_OVERRUN;
            st    <= ST_IDLE;
          end else begin
            st <= ST_EHDR;
          end
        end
        ST_EHDR: if (f_ok) begin
          ehdr_q <= f_data;
          st     <= ST_DEC;
        end
        ST_DEC: begin
          if (is_port && !dis) begin
            if (plen_bad) begin
              err_q <= ERR_PORT_LEN;
              st    <= ST_IDLE;
            end else begin
              st <= ST_PB2;
            end
          end else begin
            st <= ST_HOLD;
          end
        end
        ST_PB2: if (f_ok) begin
          b2_q <= f_data;
          st   <= ST_PB3;
        end
        ST_PB3: if (f_ok) st <= ST_HOLD;
        ST_HOLD: if (rec_valid && rec_ready) begin
          pos_q <= next_pos;
          if (at_end) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= ST_ELEN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (st != ST_IDLE);
  assign done            = done_q;
  assign err_code        = err_q;
  assign rev_warn        = warn_q;
  assign rec_is_port     = rec_q.is_port;
  assign rec_index       = rec_q.index;
  assign rec_disabled    = rec_q.disabled;
  assign rec_link        = rec_q.link;
  assign rec_has_partner = rec_q.has_partner;
  assign rec_partner     = rec_q.partner;
  assign rec_name        = rec_q.name;
  assign rec_str_len     = rec_q.str_len;

  AST_ENTRY_ADDR_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (st inside {ST_ELEN, ST_EHDR, ST_PB2, ST_PB3})) |-> (rd_addr < size_q)); // R11
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 2'd0 && !rec_valid && !busy)); // R3
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_code != 2'd0) && !start) |=> (err_code == $past(err_code))); // R12
  AST_DISABLED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_disabled) |-> (!rec_link && !rec_has_partner && rec_partner == 6'd0)); // R7

endmodule

// File: tb/cfgrom_walker_test.sv
`timescale 1ns/1ps
module cfgrom_walker_test;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, rev_warn, rd_en, rec_valid;
  logic          rec_ready = 1'b1;
  logic [1:0]    err_code;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          rec_is_port, rec_disabled, rec_link, rec_has_partner;
  logic [5:0]    rec_index, rec_partner;
  logic [1:0]    rec_name;
  logic [7:0]    rec_str_len;

  logic [7:0] mem [0:(1<<AW)-1];

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  cfgrom_walker #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err_code(err_code), .rev_warn(rev_warn), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_is_port(rec_is_port), .rec_index(rec_index), .rec_disabled(rec_disabled),
    .rec_link(rec_link), .rec_has_partner(rec_has_partner), .rec_partner(rec_partner),
    .rec_name(rec_name), .rec_str_len(rec_str_len)
  );

  int n_chk = 0;
  int n_fail = 0;

  int g_n;
  bit g_done, g_stable;
  int g_err, g_warn;
  logic [26:0] g_rec [0:15];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [26:0] pack_rec(int p, int i, int d, int l, int h, int pn, int nm, int sl);
    return {p[0], i[5:0], d[0], l[0], h[0], pn[5:0], nm[1:0], sl[7:0], 1'b0};
  endfunction

  task automatic chk_rec(input string req, input int k, input logic [26:0] exp);
    n_chk++;
    if (k >= g_n || g_rec[k] != exp) begin
      n_fail++;
      $display("FAIL %s record %0d: actual %0h expected %0h", req, k,
               (k < g_n) ? g_rec[k] : 27'h0, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'h00;
  endtask

  task automatic set_hdr(input int rev, input int lo, input int hi);
    mem[13] = rev[7:0];
    mem[14] = lo[7:0];
    mem[15] = hi[7:0];
  endtask

  task automatic put_ent(input int pos, input int len, input int hdr, input int b2, input int b3);
    mem[pos]   = len[7:0];
    mem[pos+1] = hdr[7:0];
    mem[pos+2] = b2[7:0];
    mem[pos+3] = b3[7:0];
  endtask

  task automatic run_walk(input bit stall, input bit poke);
    logic [26:0] snap, cur;
    bit hold, fin;
    g_n = 0; g_done = 0; g_stable = 1; hold = 0; fin = 0; snap = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (poke) start = (cyc == 6);
      rec_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      cur = {rec_is_port, rec_index, rec_disabled, rec_link, rec_has_partner,
             rec_partner, rec_name, rec_str_len, 1'b0};
      if (hold && (!rec_valid || cur != snap)) g_stable = 0;
      hold = rec_valid && !rec_ready;
      snap = cur;
      if (rec_valid && rec_ready && g_n < 16) begin
        g_rec[g_n] = cur;
        g_n++;
      end
      if (done) g_done = 1;
      if (done || err_code != 2'd0) begin
        fin = 1;
        g_err = int'(err_code);
        g_warn = int'(rev_warn);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    rec_ready = 1'b1;
    if (!fin) chk("R3", "walk timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "rec_valid", int'(rec_valid), 0);
    chk("R1", "err_code", int'(err_code), 0);
    chk("R1", "rev_warn", int'(rev_warn), 0);
  endtask

  task automatic t_chain();
    clear_mem();
    set_hdr(2, 39, 0);                     // size 52, revision at the limit
    put_ent(22, 6, 8'h01, 0, 0);           // vendor name
    put_ent(28, 8, 8'h83, 8'h90, 8'h45);   // port 3, link 1, partner 5
    put_ent(36, 3, 8'hC4, 8'hFF, 0);       // disabled port, short length
    mem[38] = 8'hFF;
    put_ent(39, 3, 8'h02, 8'h41, 0);       // device name
    put_ent(42, 2, 8'h07, 8'h08, 8'h08);   // other generic
    put_ent(44, 8, 8'h89, 8'h10, 8'h3F);   // port 9, link only
    run_walk(1'b1, 1'b1);
    chk("R3", "done", int'(g_done), 1);
    chk("R3", "record count", g_n, 6);
    chk("R9", "warn at rev 2", g_warn, 0);
    chk("R10", "stable under stall", int'(g_stable), 1);
    chk("R12", "start while busy ignored err", g_err, 0);
    chk_rec("R8",  0, pack_rec(0, 1, 0, 0, 0, 0, 1, 4));
    chk_rec("R7",  1, pack_rec(1, 3, 0, 1, 1, 5, 0, 0));
    chk_rec("R4",  2, pack_rec(1, 4, 1, 0, 0, 0, 0, 0));
    chk_rec("R8",  3, pack_rec(0, 2, 0, 0, 0, 0, 2, 1));
    chk_rec("R8",  4, pack_rec(0, 7, 0, 0, 0, 0, 0, 0));
    chk_rec("R7",  5, pack_rec(1, 9, 0, 1, 0, 0, 0, 0));
  endtask

  task automatic t_small();
    clear_mem();
    set_hdr(3, 8'h08, 8'hFC);              // masked length 8 -> size 21
    put_ent(22, 4, 8'h01, 0, 0);
    run_walk(1'b0, 1'b0);
    chk("R2", "too small err", g_err, 1);
    chk("R2", "no records", g_n, 0);
    chk("R9", "warn with error", g_warn, 1);
  endtask

  task automatic t_empty();
    clear_mem();
    set_hdr(8'hFF, 8'h09, 8'h04);          // size exactly 22
    run_walk(1'b0, 1'b0);
    chk("R2", "header-only done", int'(g_done), 1);
    chk("R2", "header-only records", g_n, 0);
    chk("R9", "warn with done", g_warn, 1);
    chk("R9", "no error", g_err, 0);
  endtask

  task automatic t_large();
    clear_mem();
    set_hdr(1, 8'h03, 8'hFD);              // length 0x103 -> size 272
    for (int k = 0; k < 5; k++) put_ent(22 + 50*k, 50, 5, 0, 0);
    run_walk(1'b0, 1'b0);
    chk("R2", "wide length done", int'(g_done), 1);
    chk("R2", "wide length records", g_n, 5);
  endtask

  task automatic t_zero_len();
    clear_mem();
    set_hdr(0, 27, 0);                     // size 40
    put_ent(22, 4, 8'h01, 0, 0);
    put_ent(26, 0, 8'h02, 0, 0);
    run_walk(1'b0, 1'b0);
    chk("R5", "zero length err", g_err, 2);
    chk("R5", "records before zero", g_n, 1);
    chk_rec("R5", 0, pack_rec(0, 1, 0, 0, 0, 0, 1, 2));
  endtask

  task automatic t_one_short();
    clear_mem();
    set_hdr(0, 14, 0);                     // size 27
    put_ent(22, 4, 8'h05, 0, 0);
    mem[26] = 8'd1;
    run_walk(1'b0, 1'b0);
    chk("R5", "one short err", g_err, 2);
    chk("R5", "one short records", g_n, 1);
  endtask

  task automatic t_exceed();
    clear_mem();
    set_hdr(0, 17, 0);                     // size 30
    put_ent(22, 10, 8'h01, 0, 0);
    run_walk(1'b0, 1'b0);
    chk("R5", "exceed err", g_err, 2);
    chk("R5", "exceed records", g_n, 0);
  endtask

  task automatic t_port_len();
    clear_mem();
    set_hdr(0, 16, 0);                     // size 29
    put_ent(22, 7, 8'h82, 8'h90, 1);
    run_walk(1'b0, 1'b0);
    chk("R6", "port length err", g_err, 3);
    chk("R6", "port length records", g_n, 0);
    repeat (4) @(negedge clk);
    chk("R12", "error held", int'(err_code), 3);
    clear_mem();
    set_hdr(0, 9, 0);
    run_walk(1'b0, 1'b0);
    chk("R12", "error cleared by start", g_err, 0);
    chk("R12", "restart done", int'(g_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_small();
    t_empty();
    t_large();
    t_zero_len();
    t_one_short();
    t_exceed();
    t_port_len();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule